// File: doc/BRIEF.md
# I2C Slave Receive Engine with Status Codes

This block is the receive half of an I2C target. It samples the two bus lines through synchronizers and recognises START, repeated START and STOP conditions. It compares incoming address bytes against a programmed own address, which can be 7 or 10 bits wide. It can also accept the all-zero general call address. Each data byte it accepts is acknowledged or refused according to a software-controlled enable bit.

After every reportable event the engine raises an interrupt flag and loads an 8-bit status code that identifies the event. While the flag is pending after a byte, the engine holds SCL low. Software reads the status and the received byte, then pulses the clear input. That releases the clock and lets the transfer continue.

A stub input stands in for the master's arbitration-lost indication. When it is high at the moment the address is accepted, the engine reports the alternative entry codes.

Top module: `i2c_srx`

## Requirements
- R1: After reset the flag is 0, the status reads F8h, and neither SCL nor SDA is driven low.
- R2: In 7-bit mode, an address byte whose upper seven bits equal own_addr[6:0] and whose last bit (R/W) is 0 is acknowledged, and the engine sets the flag with status 60h. The code is 68h instead when arb_lost is high. Any other address byte, including a matching address with R/W = 1, gets no acknowledge and sets no flag.
- R3: Address byte 00h is acknowledged with status 70h (78h with arb_lost high), but only while gc_en is 1. With gc_en at 0 it gets no acknowledge and sets no flag.
- R4: While ack_en is 1, every data byte is acknowledged and appears on rx_data. The flag is set with status 80h after an own-address match, or 90h after a general call.
- R5: While ack_en is 0, a data byte gets no acknowledge, and the status is 88h (own address) or 98h (general call). Clearing the flag returns the engine to idle with status F8h. Further bytes are then refused with no flag until a new START.
- R6: A STOP during the data phase sets the flag with status A0h without holding SCL, and clearing it gives F8h. A repeated START during the data phase also loads A0h. After that flag is cleared, the next byte is decoded as an address.
- R7: With addr10_en set, a first byte of 11110 followed by own_addr[9:8] and R/W = 0 is acknowledged without setting the flag or changing the status. A following byte equal to own_addr[7:0] is acknowledged with status 60h. A mismatching second byte gets no acknowledge.
- R8: Once set, the flag and the status stay unchanged until flag_clr is pulsed.
- R9: While the flag is set for any code other than A0h, scl_oe holds SCL low. scl_oe is never active without the flag, and it drops when the flag is cleared.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Both lines are seen through two-stage synchronizers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (acknowledge) |
| own_addr | input | 10 | Own address; bits 6:0 in 7-bit mode |
| addr10_en | input | 1 | Select 10-bit own address |
| gc_en | input | 1 | Accept the general call address |
| ack_en | input | 1 | Acknowledge received data bytes |
| arb_lost | input | 1 | Entry after lost arbitration (stub) |
| flag_clr | input | 1 | One-cycle pulse that clears the flag |
| flag | output | 1 | Interrupt flag |
| status | output | 8 | Status code of the last event |
| rx_data | output | 8 | Last received data byte |

## Verification
The checker assumes that flag_clr is pulsed only while the flag is set. It also assumes that SDA moves only while SCL is low, except when the master forms a START or STOP. Each bus level must also last many clocks, so the synchronizers see every edge.

The behavioural master in the bench follows these assumptions: it waits a fixed multiple of clocks between line changes, and it waits for SCL to be seen high before it continues. It clears the flag before it issues the next clock or condition. The configuration inputs change only between transfers.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR2,
        S_DATA,
        S_ACK,
        S_HOLD
    } srx_state_e;

    localparam logic [7:0] ST_OWN_W    = 8'h60;
    localparam logic [7:0] ST_OWN_LOST = 8'h68;
    localparam logic [7:0] ST_GC       = 8'h70;
    localparam logic [7:0] ST_GC_LOST  = 8'h78;
    localparam logic [7:0] ST_OWN_ACK  = 8'h80;
    localparam logic [7:0] ST_OWN_NACK = 8'h88;
    localparam logic [7:0] ST_GC_ACK   = 8'h90;
    localparam logic [7:0] ST_GC_NACK  = 8'h98;
    localparam logic [7:0] ST_END      = 8'hA0;
    localparam logic [7:0] ST_IDLE     = 8'hF8;

    localparam logic [4:0] TENBIT_HDR  = 5'b11110;

    typedef struct packed {
        logic       ack;
        logic       raise;
        logic [7:0] code;
        srx_state_e nxt;
    } srx_dec_t;

    function automatic logic [7:0] pick_code(input logic alt,
                                             input logic [7:0] norm,
                                             input logic [7:0] other);
        return alt ? other : norm;
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '1;
            else     pipe <= {pipe[STAGES-2:0], din[g]};
        end
        assign dout[g] = pipe[STAGES-1];
    end
endmodule

// File: rtl/srx_cond.sv
module srx_cond (
    input  logic clk,
    input  logic rst,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/srx_engine.sv
module srx_engine
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              sda_s,
    input  logic [9:0]        own_addr,
    input  logic              addr10_en,
    input  logic              gc_en,
    input  logic              ack_en,
    input  logic              arb_lost,
    input  logic              flag_clr,
    output logic              flag,
    output logic [7:0]        status,
    output logic [BYTE_W-1:0] rx_data,
    output logic              scl_hold,
    output logic              sda_drive
);
    srx_state_e        state, after;
    logic [BYTE_W-2:0] shreg;
    logic [CNT_W-1:0]  bcnt;
    logic              gc_mode, dec_gc;
    srx_dec_t          pend, dec;
    logic [BYTE_W-1:0] rx_byte;

    assign rx_byte = {shreg, sda_s};

    // Decision for the byte completing on this SCL rise
    always_comb begin
        dec    = '{ack: 1'b0, raise: 1'b0, code: ST_IDLE, nxt: S_IDLE};
        dec_gc = gc_mode;
        unique case (state)
            S_ADDR: begin
                if (!addr10_en && rx_byte[7:1] == own_addr[6:0] && !rx_byte[0]) begin
                    dec    = '{ack: 1'b1, raise: 1'b1,
                               code: pick_code(arb_lost, ST_OWN_W, ST_OWN_LOST), nxt: S_DATA};
                    dec_gc = 1'b0;
                end else if (addr10_en && rx_byte[7:3] == TENBIT_HDR &&
                             rx_byte[2:1] == own_addr[9:8] && !rx_byte[0]) begin
                    dec    = '{ack: 1'b1, raise: 1'b0, code: ST_IDLE, nxt: S_ADDR2};
                end else if (gc_en && rx_byte == '0) begin
                    dec    = '{ack: 1'b1, raise: 1'b1,
                               code: pick_code(arb_lost, ST_GC, ST_GC_LOST), nxt: S_DATA};
                    dec_gc = 1'b1;
                end
            end
            S_ADDR2: begin
                if (rx_byte == own_addr[7:0]) begin
                    dec    = '{ack: 1'b1, raise: 1'b1,
                               code: pick_code(arb_lost, ST_OWN_W, ST_OWN_LOST), nxt: S_DATA};
                    dec_gc = 1'b0;
                end
            end
            S_DATA: begin
                if (ack_en)
                    dec = '{ack: 1'b1, raise: 1'b1,
                            code: pick_code(gc_mode, ST_OWN_ACK, ST_GC_ACK), nxt: S_DATA};
                else
                    dec = '{ack: 1'b0, raise: 1'b1,
                            code: pick_code(gc_mode, ST_OWN_NACK, ST_GC_NACK), nxt: S_IDLE};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            after     <= S_IDLE;
            shreg     <= '0;
            bcnt      <= '0;
            gc_mode   <= 1'b0;
            pend      <= '{ack: 1'b0, raise: 1'b0, code: ST_IDLE, nxt: S_IDLE};
            flag      <= 1'b0;
            status    <= ST_IDLE;
            rx_data   <= '0;
            scl_hold  <= 1'b0;
            sda_drive <= 1'b0;
        end else if ((start_p || stop_p) && state != S_HOLD && state != S_ACK) begin
            bcnt <= '0;
            if (state == S_DATA) begin
                flag     <= 1'b1;
                status   <= ST_END;
                scl_hold <= start_p;
                after    <= start_p ? S_ADDR : S_IDLE;
                state    <= S_HOLD;
            end else if (start_p) begin
                state <= S_ADDR;
            end else begin
                state  <= S_IDLE;
                status <= ST_IDLE;
            end
        end else begin
            unique case (state)
                S_ADDR, S_ADDR2, S_DATA: begin
                    if (scl_rise && bcnt != CNT_W'(BYTE_W)) begin
                        shreg <= {shreg[BYTE_W-3:0], sda_s};
                        bcnt  <= bcnt + 1'b1;
                        if (bcnt == CNT_W'(BYTE_W - 1)) begin
                            pend    <= dec;
                            gc_mode <= dec_gc;
                            if (state == S_DATA) rx_data <= rx_byte;
                        end
                    end else if (scl_fall && bcnt == CNT_W'(BYTE_W)) begin
                        state     <= S_ACK;
                        sda_drive <= pend.ack;
                        bcnt      <= '0;
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        sda_drive <= 1'b0;
                        if (pend.raise) begin
                            flag     <= 1'b1;
                            status   <= pend.code;
                            scl_hold <= 1'b1;
                            after    <= pend.nxt;
                            state    <= S_HOLD;
                        end else begin
                            state <= pend.nxt;
                            if (pend.nxt == S_IDLE) status <= ST_IDLE;
                        end
                    end
                end
                S_HOLD: begin
                    if (flag_clr) begin
                        flag     <= 1'b0;
                        scl_hold <= 1'b0;
                        state    <= after;
                        if (after == S_IDLE) status <= ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_srx.sv
module i2c_srx
    import srx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic [9:0]  own_addr,
    input  logic        addr10_en,
    input  logic        gc_en,
    input  logic        ack_en,
    input  logic        arb_lost,
    input  logic        flag_clr,
    output logic        flag,
    output logic [7:0]  status,
    output logic [7:0]  rx_data
);
    logic [1:0] line_s;
    logic       scl_rise, scl_fall, start_p, stop_p;

    srx_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({scl_i, sda_i}),
        .dout (line_s)
    );

    srx_cond u_cond (
        .clk      (clk),
        .rst      (rst),
        .scl_s    (line_s[1]),
        .sda_s    (line_s[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    srx_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_p   (start_p),
        .stop_p    (stop_p),
        .sda_s     (line_s[0]),
        .own_addr  (own_addr),
        .addr10_en (addr10_en),
        .gc_en     (gc_en),
        .ack_en    (ack_en),
        .arb_lost  (arb_lost),
        .flag_clr  (flag_clr),
        .flag      (flag),
        .status    (status),
        .rx_data   (rx_data),
        .scl_hold  (scl_oe),
        .sda_drive (sda_oe)
    );
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
    input logic       clk,
    input logic       rst,
    input logic       flag,
    input logic       flag_clr,
    input logic [7:0] status,
    input logic       scl_oe,
    input logic       sda_oe
);
    // R9: byte events stretch the clock while pending
    p_hold_byte_r9: assert property (@(posedge clk) disable iff (rst)
        (flag && status != 8'hA0) |-> scl_oe);

    // R9: no stretching without a pending flag
    p_hold_needs_flag_r9: assert property (@(posedge clk) disable iff (rst)
        scl_oe |-> flag);

    // R9: the acknowledge is never driven while the clock is held
    p_ack_not_held_r9: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> !scl_oe);

    // R8: flag persists until cleared
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);

    // R8: status frozen while the flag waits
    p_code_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> $stable(status));

    // R5: clearing a refused-byte event lands in idle
    p_nack_idle_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(flag) && ($past(status) == 8'h88 || $past(status) == 8'h98))
        |-> status == 8'hF8);

    // R2: a raised flag always carries a defined code
    p_code_valid_r2: assert property (@(posedge clk) disable iff (rst)
        flag |-> (status inside {8'h60, 8'h68, 8'h70, 8'h78, 8'h80,
                                 8'h88, 8'h90, 8'h98, 8'hA0}));
endmodule

bind i2c_srx srx_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .flag     (flag),
    .flag_clr (flag_clr),
    .status   (status),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe)
);

// File: tb/i2c_srx_tb.sv
module i2c_srx_tb;
    localparam int CLK_P = 10;
    localparam int HB    = 8;
    localparam int WDOG  = 150000;

    typedef struct packed {
        logic [7:0] d;
        logic       ack;
        logic [7:0] code;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{d: 8'h3C, ack: 1'b1, code: 8'h80},
        '{d: 8'hFF, ack: 1'b1, code: 8'h80},
        '{d: 8'h00, ack: 1'b1, code: 8'h80},
        '{d: 8'hA5, ack: 1'b1, code: 8'h80},
        '{d: 8'h5A, ack: 1'b0, code: 8'h88}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl_lo = 1'b0, m_sda_lo = 1'b0;
    logic       scl_bus, sda_bus;
    logic       scl_oe, sda_oe;
    logic [9:0] own_addr = 10'h2A5;
    logic       addr10_en = 1'b0, gc_en = 1'b0, ack_en = 1'b1, arb_lost = 1'b0;
    logic       flag_clr = 1'b0;
    logic       flag;
    logic [7:0] status, rx_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    assign scl_bus = !(m_scl_lo || scl_oe);
    assign sda_bus = !(m_sda_lo || sda_oe);

    i2c_srx u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr),
        .addr10_en(addr10_en), .gc_en(gc_en), .ack_en(ack_en),
        .arb_lost(arb_lost), .flag_clr(flag_clr), .flag(flag),
        .status(status), .rx_data(rx_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl_lo = 1'b0;
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_lo = 1'b0; idle(HB);
        scl_up();        idle(HB);
        m_sda_lo = 1'b1; idle(HB);
        m_scl_lo = 1'b1; idle(HB);
    endtask

    task automatic bus_stop();
        m_sda_lo = 1'b1; idle(HB);
        scl_up();        idle(HB);
        m_sda_lo = 1'b0; idle(HB);
    endtask

    task automatic bus_bit(input logic b, output logic r);
        m_sda_lo = !b; idle(HB);
        scl_up();      idle(HB);
        r = sda_bus;
        m_scl_lo = 1'b1; idle(HB);
    endtask

    // returns the 9th-clock SDA level: 0 = acknowledged
    task automatic send_byte(input logic [7:0] b, output logic nack);
        logic dummy;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], dummy);
        bus_bit(1'b1, nack);
        m_sda_lo = 1'b0;
    endtask

    task automatic clr();
        flag_clr = 1'b1; @(negedge clk);
        flag_clr = 1'b0; @(negedge clk);
    endtask

    task automatic expect_evt(input string req, input logic nack_exp, input logic nack,
                              input logic [7:0] code);
        chk(nack == nack_exp, req, nack, nack_exp);
        chk(flag == 1'b1, req, flag, 1);
        chk(status == code, req, status, code);
    endtask

    initial begin : watchdog
        for (int c = 0; c < WDOG; c++) begin
            @(negedge clk);
            if (done) disable watchdog;
        end
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected=<%0d", WDOG, WDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic nk;
        m_scl_lo = 1'b0; m_sda_lo = 1'b0;
        idle(5);
        rst = 1'b0;
        idle(5);

        // R1 reset state
        chk(flag == 1'b0, "R1 flag", flag, 0);
        chk(status == 8'hF8, "R1 status", status, 8'hF8);
        chk(!scl_oe && !sda_oe, "R1 lines", {scl_oe, sda_oe}, 0);

        // R2 own 7-bit write address, R10 START detection
        bus_start();
        send_byte({own_addr[6:0], 1'b0}, nk);
        expect_evt("R2 R10 own addr", 1'b0, nk, 8'h60);
        chk(scl_oe == 1'b1, "R9 stretch", scl_oe, 1);
        idle(20);
        chk(flag == 1'b1 && status == 8'h60, "R8 held", {flag, status}, {1'b1, 8'h60});
        clr();
        chk(scl_oe == 1'b0, "R9 release", scl_oe, 0);

        // table walk: R4 acked data, R5 refused data
        foreach (VECS[i]) begin
            ack_en = VECS[i].ack;
            send_byte(VECS[i].d, nk);
            expect_evt(VECS[i].ack ? "R4 data" : "R5 data", !VECS[i].ack, nk, VECS[i].code);
            chk(rx_data == VECS[i].d, "R4 rx_data", rx_data, VECS[i].d);
            clr();
        end
        chk(status == 8'hF8, "R5 idle", status, 8'hF8);
        ack_en = 1'b1;
        send_byte(8'h11, nk);
        chk(nk == 1'b1 && flag == 1'b0 && status == 8'hF8, "R5 ignored",
            {nk, flag, status}, {1'b1, 1'b0, 8'hF8});
        bus_stop();

        // R2 mismatches
        bus_start();
        send_byte({own_addr[6:0] ^ 7'h01, 1'b0}, nk);
        chk(nk == 1'b1 && flag == 1'b0, "R2 wrong addr", {nk, flag}, 2'b10);
        bus_stop();
        bus_start();
        send_byte({own_addr[6:0], 1'b1}, nk);
        chk(nk == 1'b1 && flag == 1'b0, "R2 read bit", {nk, flag}, 2'b10);
        bus_stop();

        // R3 general call disabled then enabled
        bus_start();
        send_byte(8'h00, nk);
        chk(nk == 1'b1 && flag == 1'b0, "R3 gc off", {nk, flag}, 2'b10);
        bus_stop();
        gc_en = 1'b1;
        bus_start();
        send_byte(8'h00, nk);
        expect_evt("R3 gc on", 1'b0, nk, 8'h70);
        clr();
        send_byte(8'h77, nk);
        expect_evt("R4 gc data", 1'b0, nk, 8'h90);
        chk(rx_data == 8'h77, "R4 gc rx_data", rx_data, 8'h77);
        clr();
        ack_en = 1'b0;
        send_byte(8'h12, nk);
        expect_evt("R5 gc nack", 1'b1, nk, 8'h98);
        clr();
        chk(status == 8'hF8, "R5 gc idle", status, 8'hF8);
        ack_en = 1'b1;
        bus_stop();

        // R2/R3 arbitration-lost entry codes, R6 STOP
        arb_lost = 1'b1;
        bus_start();
        send_byte({own_addr[6:0], 1'b0}, nk);
        expect_evt("R2 arb own", 1'b0, nk, 8'h68);
        clr();
        bus_stop();
        chk(flag == 1'b1 && status == 8'hA0, "R6 stop", {flag, status}, {1'b1, 8'hA0});
        chk(scl_oe == 1'b0, "R6 no stretch", scl_oe, 0);
        clr();
        chk(status == 8'hF8, "R6 idle", status, 8'hF8);
        bus_start();
        send_byte(8'h00, nk);
        expect_evt("R3 arb gc", 1'b0, nk, 8'h78);
        clr();
        bus_stop();
        clr();
        arb_lost = 1'b0;

        // R6 repeated START
        bus_start();
        send_byte({own_addr[6:0], 1'b0}, nk);
        clr();
        send_byte(8'hC3, nk);
        expect_evt("R4 pre-rstart", 1'b0, nk, 8'h80);
        clr();
        bus_start();
        chk(flag == 1'b1 && status == 8'hA0, "R6 rstart", {flag, status}, {1'b1, 8'hA0});
        clr();
        send_byte({own_addr[6:0], 1'b0}, nk);
        expect_evt("R6 readdress", 1'b0, nk, 8'h60);
        clr();
        bus_stop();
        clr();

        // R7 10-bit addressing
        addr10_en = 1'b1;
        bus_start();
        send_byte({5'b11110, own_addr[9:8], 1'b0}, nk);
        chk(nk == 1'b0 && flag == 1'b0 && status == 8'hF8, "R7 first byte",
            {nk, flag, status}, {1'b0, 1'b0, 8'hF8});
        send_byte(own_addr[7:0], nk);
        expect_evt("R7 second byte", 1'b0, nk, 8'h60);
        clr();
        send_byte(8'h5E, nk);
        expect_evt("R7 data", 1'b0, nk, 8'h80);
        chk(rx_data == 8'h5E, "R7 rx_data", rx_data, 8'h5E);
        clr();
        bus_stop();
        clr();
        bus_start();
        send_byte({5'b11110, own_addr[9:8], 1'b0}, nk);
        send_byte(own_addr[7:0] ^ 8'h01, nk);
        chk(nk == 1'b1 && flag == 1'b0, "R7 second mismatch", {nk, flag}, 2'b10);
        bus_stop();
        bus_start();
        send_byte({own_addr[6:0], 1'b0}, nk);
        chk(nk == 1'b1 && flag == 1'b0, "R7 7-bit refused", {nk, flag}, 2'b10);
        bus_stop();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule